// File: doc/BRIEF.md
# Banked Message Interrupt Status and Mask Unit

This unit sits behind an inbound write path of a root port. It turns message-signalled interrupt writes into pending bits. An inbound write counts as an interrupt only when its 64-bit address equals a programmed target address and decoding is switched on. Its data word then selects one of 64 vectors. The vectors are held in two 32-bit status banks: a lower bank for vectors 0 to 31 and an upper bank for vectors 32 to 63. Each bank has its own enable mask and its own registered interrupt line.

Software uses a small word-indexed register port. Through it, software programs the target address, switches decoding and capture on, reads the pending bits and clears them by writing ones. The inbound write stream is a valid/ready interface. `msi_ready` is held high at all times, so the block never applies back-pressure. A beat is taken in every cycle in which `msi_valid` is high, and a cycle with `msi_valid` low carries no event.

Top module: `msi_vector_banks`

## Requirements
- R1: After reset, every status, mask, control and target-address register reads zero and both interrupt lines are low. The read-only word at index 0 returns 1 in bit 0 (unit present), and writes to that word have no effect.
- R2: An accepted beat with data n < 32 sets bit n of the lower status word (index 4). An accepted beat with 32 <= n < 64 sets bit n-32 of the upper status word (index 5). The bit can be read in the cycle after the beat.
- R3: A register write to status word 4 or 5 clears exactly the bits written as 1 and leaves every other bit unchanged.
- R4: Mask words sit at index 6 (lower) and 7 (upper), and a mask bit of 1 enables its vector. Each bank's interrupt line is the OR of status AND mask, registered one clock after the status or mask change. A bank whose mask is all zero keeps its line low.
- R5: `irq_lo` reflects only the lower bank and `irq_hi` reflects only the upper bank.
- R6: Control word index 1 holds two enables, and both must be 1 for a beat to set a status bit: decode enable in bit 0 and capture enable in bit 15. The other bits of this word read as zero.
- R7: The target address is written as a low word (index 2) and a high word (index 3). A beat whose address differs from the target in any bit sets nothing.
- R8: If a beat setting bit k and a register clear of bit k land in the same cycle, bit k is set afterwards.
- R9: A status bit is captured even while its mask bit is 0. Setting the mask bit later raises the line one clock after the mask write.
- R10: A beat with data 64 or above sets no bit in either bank.
- R11: `msi_ready` is always 1, and a cycle with `msi_valid` low sets nothing, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound write beat valid |
| msi_ready | output | 1 | Always 1; no back-pressure |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_lo | output | 1 | Interrupt for vectors 0 to 31 |
| irq_hi | output | 1 | Interrupt for vectors 32 to 63 |

## Verification
The hardest case to reach from the ports is a set and a clear of the same status bit landing on one clock edge. The bench reaches it by driving an inbound beat and a status-word register write in the same low clock phase. It does this once where both target the same bit, and once where they target different bits, so that both the priority rule and the clear of the untouched bits are seen. Interrupt latency is checked one edge at a time after a mask write. This shows that a vector pending while masked appears one clock later, and not in the cycle of the write.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int NUM_BANKS = 2;
  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] IDX_CAP     = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_TGT_LO  = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_TGT_HI  = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STAT_LO = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_STAT_HI = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_MASK_LO = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_MASK_HI = 3'd7;

  localparam int CTRL_DECODE_BIT  = 0;
  localparam int CTRL_CAPTURE_BIT = 15;
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int NUM_VEC = 64,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  parameter bit PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [ADDR_W-1:0]  target,
  input  logic               decode_en,
  input  logic               capture_en,
  output logic [NUM_VEC-1:0] set_vec
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic hit;

  always_comb begin
    hit = in_valid && PRESENT && decode_en && capture_en &&
          (in_addr == target) && (in_data < DATA_W'(NUM_VEC));
    set_vec = '0;
    if (hit) set_vec[in_data[IDX_W-1:0]] = 1'b1;
  end

  p_single_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data >= DATA_W'(NUM_VEC)) |-> (set_vec == '0));
  p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(decode_en && capture_en) |-> (set_vec == '0));
  p_idle_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (set_vec == '0));
endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (mask_we) mask <= mask_wdata;
      irq <= |(status & mask);
    end
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  p_clear_only_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(clr_vec | set_vec)) ==
              ($past(status) & ~$past(clr_vec | set_vec))));
  p_irq_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status) & $past(mask))));
endmodule

// File: rtl/msi_vector_banks.sv
module msi_vector_banks
  import msi_bank_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int BANK_W  = 32,
  parameter bit PRESENT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msi_valid,
  output logic                 msi_ready,
  input  logic [2*REG_W-1:0]   msi_addr,
  input  logic [REG_W-1:0]     msi_data,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq_lo,
  output logic                 irq_hi
);
  localparam int NUM_VEC = NUM_BANKS * BANK_W;
  localparam int ADDR_W  = 2 * REG_W;

  logic              decode_en, capture_en;
  logic [REG_W-1:0]  tgt_lo, tgt_hi;
  logic [NUM_VEC-1:0] set_vec;
  logic [BANK_W-1:0] bank_status [NUM_BANKS];
  logic [BANK_W-1:0] bank_mask   [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign msi_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decode_en  <= 1'b0;
      capture_en <= 1'b0;
      tgt_lo     <= '0;
      tgt_hi     <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        IDX_CTRL: begin
          decode_en  <= reg_wdata[CTRL_DECODE_BIT];
          capture_en <= reg_wdata[CTRL_CAPTURE_BIT];
        end
        IDX_TGT_LO: tgt_lo <= reg_wdata;
        IDX_TGT_HI: tgt_hi <= reg_wdata;
        default: ;
      endcase
    end
  end

  msi_vec_decode #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(REG_W), .PRESENT(PRESENT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .in_valid(msi_valid), .in_addr(msi_addr), .in_data(msi_data),
    .target({tgt_hi, tgt_lo}),
    .decode_en(decode_en), .capture_en(capture_en),
    .set_vec(set_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [REG_IDX_W-1:0] STAT_IDX = IDX_STAT_LO + REG_IDX_W'(b);
    localparam logic [REG_IDX_W-1:0] MASK_IDX = IDX_MASK_LO + REG_IDX_W'(b);
    logic [BANK_W-1:0] clr;
    logic              mwe;
    assign clr = (reg_we && reg_addr == STAT_IDX) ? reg_wdata[BANK_W-1:0] : '0;
    assign mwe = reg_we && (reg_addr == MASK_IDX);

    msi_status_bank #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec[b*BANK_W +: BANK_W]),
      .clr_vec(clr),
      .mask_we(mwe),
      .mask_wdata(reg_wdata[BANK_W-1:0]),
      .status(bank_status[b]),
      .mask(bank_mask[b]),
      .irq(bank_irq[b])
    );
  end

  assign irq_lo = bank_irq[0];
  assign irq_hi = bank_irq[1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_CAP:     reg_rdata[0] = PRESENT;
      IDX_CTRL: begin
        reg_rdata[CTRL_DECODE_BIT]  = decode_en;
        reg_rdata[CTRL_CAPTURE_BIT] = capture_en;
      end
      IDX_TGT_LO:  reg_rdata = tgt_lo;
      IDX_TGT_HI:  reg_rdata = tgt_hi;
      IDX_STAT_LO: reg_rdata = REG_W'(bank_status[0]);
      IDX_STAT_HI: reg_rdata = REG_W'(bank_status[1]);
      IDX_MASK_LO: reg_rdata = REG_W'(bank_mask[0]);
      IDX_MASK_HI: reg_rdata = REG_W'(bank_mask[1]);
      default: ;
    endcase
  end

  p_ready_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ready);
  p_lines_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_status[1] == '0) |=> !irq_hi);
endmodule

// File: tb/msi_vector_banks_tb.sv
module msi_vector_banks_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_vector_banks u_dut (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d, input logic v);
    @(negedge clk);
    msi_valid = v; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic msi_and_clear(input logic [31:0] d, input logic [2:0] a, input logic [31:0] c);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = TGT; msi_data = d;
    reg_we = 1'b1; reg_addr = a; reg_wdata = c;
    @(negedge clk);
    msi_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cap", {31'd0, 1'b1} & 32'h1, 32'h1);
    chk_reg("R1 cap word", 3'd0, 32'h1);
    for (int i = 1; i < 8; i++) chk_reg("R1 reg zero", 3'(i), 32'h0);
    chk("R1 irq_lo", {31'd0, irq_lo}, 0);
    chk("R1 irq_hi", {31'd0, irq_hi}, 0);
    wr(3'd0, 32'h0);
    chk_reg("R1 cap write ignored", 3'd0, 32'h1);
  endtask

  task automatic t_setup;
    wr(3'd1, 32'hFFFF_FFFF);
    chk_reg("R6 ctrl readback", 3'd1, 32'h0000_8001);
    wr(3'd2, TGT[31:0]);
    wr(3'd3, TGT[63:32]);
    chk_reg("R7 target lo", 3'd2, TGT[31:0]);
    chk_reg("R7 target hi", 3'd3, TGT[63:32]);
  endtask

  task automatic t_mapping;
    msi(TGT, 32'd5, 1'b1);
    chk_reg("R2 low bank vec5", 3'd4, 32'h0000_0020);
    chk_reg("R2 high untouched", 3'd5, 32'h0);
    msi(TGT, 32'd40, 1'b1);
    chk_reg("R2 high bank vec40", 3'd5, 32'h0000_0100);
    msi(TGT, 32'd63, 1'b1);
    chk_reg("R2 high bank vec63", 3'd5, 32'h8000_0100);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    chk_reg("R3 clear all lo", 3'd4, 32'h0);
  endtask

  task automatic t_w1c;
    msi(TGT, 32'd1, 1'b1);
    msi(TGT, 32'd2, 1'b1);
    msi(TGT, 32'd3, 1'b1);
    wr(3'd4, 32'h0000_0004);
    chk_reg("R3 only bit2 cleared", 3'd4, 32'h0000_000A);
  endtask

  task automatic t_mask_irq;
    @(negedge clk);
    @(negedge clk);
    chk("R4 all-zero mask keeps line low", {31'd0, irq_lo}, 0);
    wr(3'd6, 32'h0000_0002);
    chk("R9 not yet in write cycle", {31'd0, irq_lo}, 0);
    @(negedge clk);
    chk("R9 unmask pending raises irq_lo", {31'd0, irq_lo}, 1);
    chk("R5 irq_hi stays low", {31'd0, irq_hi}, 0);
    wr(3'd4, 32'h0000_0002);
    @(negedge clk);
    chk("R4 line drops after clear", {31'd0, irq_lo}, 0);
  endtask

  task automatic t_separate;
    wr(3'd7, 32'h0000_0100);
    wr(3'd6, 32'h0000_0008);
    msi(TGT, 32'd40, 1'b1);
    @(negedge clk);
    chk("R5 irq_hi raised by vec40", {31'd0, irq_hi}, 1);
    chk("R5 irq_lo from bit3", {31'd0, irq_lo}, 1);
    wr(3'd4, 32'h0000_0008);
    @(negedge clk);
    chk("R5 irq_lo falls alone", {31'd0, irq_lo}, 0);
    chk("R5 irq_hi unaffected", {31'd0, irq_hi}, 1);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl;
    wr(3'd1, 32'h0000_0001);
    msi(TGT, 32'd7, 1'b1);
    chk_reg("R6 decode only sets nothing", 3'd4, 32'h0);
    wr(3'd1, 32'h0000_8000);
    msi(TGT, 32'd7, 1'b1);
    chk_reg("R6 capture only sets nothing", 3'd4, 32'h0);
    wr(3'd1, 32'h0000_8001);
    msi(TGT, 32'd7, 1'b1);
    chk_reg("R6 both enables capture", 3'd4, 32'h0000_0080);
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_addr;
    msi(TGT ^ 64'h0000_0100_0000_0000, 32'd6, 1'b1);
    chk_reg("R7 wrong high word ignored", 3'd4, 32'h0);
    msi(TGT ^ 64'h4, 32'd6, 1'b1);
    chk_reg("R7 wrong low word ignored", 3'd4, 32'h0);
  endtask

  task automatic t_same_cycle;
    msi(TGT, 32'd9, 1'b1);
    msi(TGT, 32'd10, 1'b1);
    msi_and_clear(32'd9, 3'd4, 32'h0000_0200);
    chk_reg("R8 set wins over clear", 3'd4, 32'h0000_0600);
    msi_and_clear(32'd11, 3'd4, 32'h0000_0400);
    chk_reg("R8 set and clear distinct bits", 3'd4, 32'h0000_0A00);
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_range;
    msi(TGT, 32'd64, 1'b1);
    msi(TGT, 32'd200, 1'b1);
    msi(TGT, 32'h8000_0001, 1'b1);
    chk_reg("R10 low bank untouched", 3'd4, 32'h0);
    chk_reg("R10 high bank untouched", 3'd5, 32'h0);
  endtask

  task automatic t_valid;
    chk("R11 ready high", {31'd0, msi_ready}, 1);
    msi(TGT, 32'd12, 1'b0);
    chk_reg("R11 idle beat sets nothing", 3'd4, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_mapping();
    t_w1c();
    t_mask_irq();
    t_separate();
    t_ctrl();
    t_addr();
    t_same_cycle();
    t_range();
    t_valid();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule